// File: doc/BRIEF.md
# Event Statistics Counter Bank

This block keeps a set of event statistics for a ring network controller. Eight 20-bit counters tally frames received, errors isolated, frames lost, frames copied, frames not copied, frames transmitted, tokens received and ring latency. A ninth, 4-bit counter tallies late events and sticks at its maximum. Each counter advances by one on a single-cycle strobe from the logic that detects the event.

Software reaches the bank through a plain 8-bit register port. Because a 20-bit value cannot cross an 8-bit bus in one access, a read of a counter's lowest byte copies that counter's upper 12 bits into one shared holding register. The middle and top byte addresses then return the copy, so a three-read sequence yields a coherent value even while the counter keeps moving. Counters accept writes only while the stop-mode input is high, and a master reset leaves them alone. Two sticky status vectors flag increments and roll-overs and drive interrupt request outputs. The port has no streaming traffic, so it carries no valid/ready handshake: a read is a one-cycle `bus_rd` pulse and is never back-pressured, and its byte appears on `bus_rdata` one cycle later.

Top module: `evtstat_bank`

## Requirements
- R1: Each 20-bit counter (index 0 to 7) adds one on every cycle its strobe is high, and goes from 0xFFFFF to 0 on the next strobe.
- R2: The late counter (strobe bit 8) adds one per strobe up to 15 and then stays at 15 on further strobes.
- R3: Address map: counter k byte b (b=0 least significant) sits at address 3k+b, the late counter at 24 (value in bits 3:0, upper bits zero), the increment status at 25 (bits 7:0 = counters 0 to 7) and 26 (bit 0 = late counter), the wrap status at 27 and 28 with the same layout; other addresses read zero. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R4: A read of a counter's byte-0 address returns the counter's low byte and loads the counter's bits 19:8 into the holding register, both taken from the value before any event in that same cycle.
- R5: Reads of byte 1 and byte 2 return holding bits 7:0 and {4'b0, holding bits 11:8}; without a prior byte-0 read they return whatever was last captured.
- R6: A write to a counter address replaces the addressed byte when `stop_mode` is high and has no effect when it is low.
- R7: Master reset clears the holding register, both status vectors and `bus_rdata`, and leaves every counter value unchanged.
- R8: When a write and a strobe hit the same counter in one cycle, the written value is kept, the event is dropped, and no status bit is set for it.
- R9: An increment sets the counter's increment status bit, except for counter 7 (ring latency); a strobe on the late counter held at 15 sets nothing.
- R10: A roll-over sets the counter's wrap status bit, except for counter 7 and the late counter.
- R11: Writing ones to a status address clears those bits in any mode; a bit being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| stop_mode | input | 1 | High enables counter writes |
| evt_strobe | input | 9 | One-cycle event strobes; bits 0-7 wide counters, bit 8 late counter |
| bus_addr | input | 5 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| inc_irq | output | 9 | Sticky increment status / interrupt requests |
| wrap_irq | output | 9 | Sticky wrap status / interrupt requests |

## Verification
The hazards are a host access and an event strobe that land on the same counter in one cycle: a write in stop mode must beat the strobe, a byte-0 read must capture the value from before the increment, and a status clear must lose to a status set. Directed steps drive each pair in a single cycle, and random traffic drives them again with dense strobes and random addresses. A cycle-level model in the bench applies the stated priorities to judge every read byte and both status vectors after each cycle.

// File: rtl/evtstat_pkg.sv
package evtstat_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/evtstat_ctr.sv
module evtstat_ctr
  import evtstat_pkg::*;
#(
  parameter int W        = 20,
  parameter bit SATURATE = 1'b0,
  localparam int NB      = bytes_for(W),
  localparam int LO_W    = (W < BYTE_W) ? W : BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [W-1:0]      value,
  output logic              inc_pulse,
  output logic              wrap_pulse
);
  logic         wr_any;
  logic         full;
  logic [W-1:0] nxt;
  logic         unused_wbits;

  assign unused_wbits = ^wdata;
  assign wr_any = |byte_we;
  assign full   = &value;

  always_comb begin
    nxt = value;
    for (int i = 0; i < W; i++) begin
      if (byte_we[i / BYTE_W]) nxt[i] = wdata[i % BYTE_W];
    end
    if (!wr_any && evt && !(SATURATE && full)) nxt = value + 1'b1;
  end

  // Counter storage deliberately has no reset.
  always_ff @(posedge clk) begin
    value <= nxt;
  end

  assign inc_pulse  = evt && !wr_any && !(SATURATE && full);
  assign wrap_pulse = evt && !wr_any && full && !SATURATE;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_any && !(SATURATE && full)) |=> value == W'($past(value) + 1'b1));

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SATURATE && evt && !wr_any && full) |=> (&value));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we[0] |=> value[LO_W-1:0] == $past(wdata[LO_W-1:0]));
endmodule

// File: rtl/evtstat_hold.sv
module evtstat_hold #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] upper,
  output logic [HW-1:0] hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold <= '0;
    else if (load) hold <= upper;
  end

  // R4
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold == $past(upper));

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold));
endmodule

// File: rtl/evtstat_irq.sv
module evtstat_irq #(
  parameter int           N      = 9,
  parameter logic [N-1:0] EXEMPT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] set_ok;
  assign set_ok = set_pulse & ~EXEMPT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | set_ok;
  end

  // R11
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(set_ok)) == $past(set_ok));

  // R11
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(clr & ~set_ok)) == '0);
endmodule

// File: rtl/evtstat_bank.sv
module evtstat_bank
  import evtstat_pkg::*;
#(
  parameter int NUM_WIDE = 8,
  parameter int CNT_W    = 20,
  parameter int LATE_W   = 4,
  parameter int ADDR_W   = 5,
  parameter int RL_IDX   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_mode,
  input  logic [NUM_WIDE:0]   evt_strobe,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic [NUM_WIDE:0]   inc_irq,
  output logic [NUM_WIDE:0]   wrap_irq
);
  localparam int NB        = bytes_for(CNT_W);
  localparam int HOLD_W    = CNT_W - BYTE_W;
  localparam int NUM_CNT   = NUM_WIDE + 1;
  localparam int ST_NB     = bytes_for(NUM_CNT);
  localparam int LATE_ADDR = NUM_WIDE * NB;
  localparam int INC_BASE  = LATE_ADDR + 1;
  localparam int WRAP_BASE = INC_BASE + ST_NB;
  localparam logic [NUM_CNT-1:0] INC_EX  = NUM_CNT'(1) << RL_IDX;
  localparam logic [NUM_CNT-1:0] WRAP_EX = INC_EX | (NUM_CNT'(1) << NUM_WIDE);

  logic                 wr_ok;
  logic [NB-1:0]        wide_we  [NUM_WIDE];
  logic [CNT_W-1:0]     wide_val [NUM_WIDE];
  logic                 late_we;
  logic [LATE_W-1:0]    late_val;
  logic [NUM_CNT-1:0]   inc_p, wrap_p, inc_clr, wrap_clr;
  logic                 hold_load;
  logic [HOLD_W-1:0]    hold_upper, hold_q;
  logic [BYTE_W-1:0]    rd_byte;

  assign wr_ok   = bus_wr && stop_mode;
  assign late_we = wr_ok && (bus_addr == ADDR_W'(LATE_ADDR));

  // Address decode for counter bytes, status clears and snapshot load
  always_comb begin
    hold_load  = 1'b0;
    hold_upper = '0;
    for (int k = 0; k < NUM_WIDE; k++) begin
      for (int b = 0; b < NB; b++) begin
        wide_we[k][b] = wr_ok && (bus_addr == ADDR_W'(k * NB + b));
      end
      if (bus_rd && bus_addr == ADDR_W'(k * NB)) begin
        hold_load  = 1'b1;
        hold_upper = wide_val[k][CNT_W-1:BYTE_W];
      end
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      inc_clr[i]  = bus_wr && (bus_addr == ADDR_W'(INC_BASE + i / BYTE_W))
                    && bus_wdata[i % BYTE_W];
      wrap_clr[i] = bus_wr && (bus_addr == ADDR_W'(WRAP_BASE + i / BYTE_W))
                    && bus_wdata[i % BYTE_W];
    end
  end

  genvar gk;
  generate
    for (gk = 0; gk < NUM_WIDE; gk++) begin : g_wide
      evtstat_ctr #(.W(CNT_W), .SATURATE(1'b0)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_strobe[gk]),
        .byte_we    (wide_we[gk]),
        .wdata      (bus_wdata),
        .value      (wide_val[gk]),
        .inc_pulse  (inc_p[gk]),
        .wrap_pulse (wrap_p[gk])
      );
    end
  endgenerate

  evtstat_ctr #(.W(LATE_W), .SATURATE(1'b1)) u_late (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt_strobe[NUM_WIDE]),
    .byte_we    (late_we),
    .wdata      (bus_wdata),
    .value      (late_val),
    .inc_pulse  (inc_p[NUM_WIDE]),
    .wrap_pulse (wrap_p[NUM_WIDE])
  );

  evtstat_hold #(.HW(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hold_load),
    .upper (hold_upper),
    .hold  (hold_q)
  );

  evtstat_irq #(.N(NUM_CNT), .EXEMPT(INC_EX)) u_inc (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (inc_p),
    .clr       (inc_clr),
    .status    (inc_irq)
  );

  evtstat_irq #(.N(NUM_CNT), .EXEMPT(WRAP_EX)) u_wrap (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (wrap_p),
    .clr       (wrap_clr),
    .status    (wrap_irq)
  );

  // Read multiplexer: byte 0 live, higher bytes from the snapshot
  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NUM_WIDE; k++) begin
      for (int b = 0; b < NB; b++) begin
        if (bus_addr == ADDR_W'(k * NB + b)) begin
          if (b == 0) rd_byte = wide_val[k][BYTE_W-1:0];
          else        rd_byte = BYTE_W'(hold_q >> (BYTE_W * (b - 1)));
        end
      end
    end
    if (bus_addr == ADDR_W'(LATE_ADDR)) rd_byte = BYTE_W'(late_val);
    for (int s = 0; s < ST_NB; s++) begin
      if (bus_addr == ADDR_W'(INC_BASE + s))  rd_byte = BYTE_W'(inc_irq >> (BYTE_W * s));
      if (bus_addr == ADDR_W'(WRAP_BASE + s)) rd_byte = BYTE_W'(wrap_irq >> (BYTE_W * s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_byte;
  end

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R6
  late_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_mode && !evt_strobe[NUM_WIDE]) |=> $stable(late_val));

  // R10
  late_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_irq[NUM_WIDE]);
endmodule

// File: tb/evtstat_bank_bench.sv
`timescale 1ns/1ps
module evtstat_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_mode = 1'b0;
  logic [8:0] evt_strobe = '0;
  logic [4:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [8:0] inc_irq, wrap_irq;

  always #4 clk = ~clk;

  evtstat_bank u_evtstat_bank (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .evt_strobe(evt_strobe),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inc_irq(inc_irq), .wrap_irq(wrap_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [19:0] m_cnt [8];
  logic [3:0]  m_late;
  logic [11:0] m_hold = '0;
  logic [8:0]  m_inc = '0, m_wrap = '0;
  logic [7:0]  m_rdata = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [4:0] a);
    if (a < 5'd24) begin
      case (a % 3)
        0:       return m_cnt[a / 3][7:0];
        1:       return m_hold[7:0];
        default: return {4'b0, m_hold[11:8]};
      endcase
    end
    case (a)
      5'd24:   return {4'b0, m_late};
      5'd25:   return m_inc[7:0];
      5'd26:   return {7'b0, m_inc[8]};
      5'd27:   return m_wrap[7:0];
      5'd28:   return {7'b0, m_wrap[8]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [4:0] a);
    if (a < 5'd24) return (a % 3 == 0) ? "R4" : "R5";
    if (a == 5'd24 || a > 5'd28) return "R3";
    return "R11";
  endfunction

  // One bus cycle; the model is advanced using the pre-edge state
  task automatic step(input logic [8:0] ev, input bit rd, input bit wr,
                      input logic [4:0] a, input logic [7:0] d, input string tag);
    logic [8:0] written, iset, wset, iclr, wclr;
    string t;
    evt_strobe = ev; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    written = '0; iset = '0; wset = '0; iclr = '0; wclr = '0;
    if (rd) begin
      m_rdata = model_read(a);
      if (a < 5'd24 && a % 3 == 0) m_hold = m_cnt[a / 3][19:8];
    end
    if (wr) begin
      if (stop_mode && a < 5'd24) begin
        m_cnt[a / 3][8 * (a % 3) +: 8] = d;
        written[a / 3] = 1'b1;
      end
      if (stop_mode && a == 5'd24) begin
        m_late = d[3:0];
        written[8] = 1'b1;
      end
      if (a == 5'd25) iclr[7:0] = d;
      if (a == 5'd26) iclr[8]   = d[0];
      if (a == 5'd27) wclr[7:0] = d;
      if (a == 5'd28) wclr[8]   = d[0];
    end
    for (int k = 0; k < 8; k++) begin
      if (ev[k] && !written[k]) begin
        if (m_cnt[k] == 20'hFFFFF && k != 7) wset[k] = 1'b1;
        if (k != 7) iset[k] = 1'b1;
        m_cnt[k] = m_cnt[k] + 1'b1;
      end
    end
    if (ev[8] && !written[8] && m_late != 4'hF) begin
      m_late = m_late + 1'b1;
      iset[8] = 1'b1;
    end
    m_inc  = (m_inc & ~iclr) | iset;
    m_wrap = (m_wrap & ~wclr) | wset;
    @(posedge clk);
    @(negedge clk);
    t = (tag != "") ? tag : (rd ? read_tag(a) : "R3");
    check({t, " rdata"}, 32'(bus_rdata), 32'(m_rdata));
    check({t, " R9 inc status"}, 32'(inc_irq), 32'(m_inc));
    check({t, " R10 wrap status"}, 32'(wrap_irq), 32'(m_wrap));
    evt_strobe = '0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_hold = '0; m_inc = '0; m_wrap = '0; m_rdata = '0;
    check("R7 rdata after reset", 32'(bus_rdata), 32'h0);
    check("R7 status after reset", 32'({inc_irq, wrap_irq}), 32'h0);
  endtask

  task automatic load_wide(input int k, input logic [19:0] v, input string tag);
    step('0, 0, 1, 5'(3 * k),     v[7:0],           tag);
    step('0, 0, 1, 5'(3 * k + 1), v[15:8],          tag);
    step('0, 0, 1, 5'(3 * k + 2), {4'b0, v[19:16]}, tag);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    @(negedge clk);
    pulse_reset();
    step('0, 1, 0, 5'd1, 8'h00, "R7 hold cleared");

    // Clear all counters in stop mode
    stop_mode = 1'b1;
    for (int a = 0; a < 25; a++) step('0, 0, 1, 5'(a), 8'h00, "R6");
    for (int a = 0; a < 25; a++) step('0, 1, 0, 5'(a), 8'h00, "R6 zeroed");

    // R1 and R10: roll-over on counter 0 and on ring latency counter 7
    load_wide(0, 20'hFFFFF, "R1");
    load_wide(7, 20'hFFFFF, "R10");
    step(9'h081, 0, 0, 5'd0, 8'h00, "R1 R10 wrap");
    step('0, 1, 0, 5'd0, 8'h00, "R1 low after wrap");
    step('0, 1, 0, 5'd2, 8'h00, "R1 top after wrap");
    step('0, 1, 0, 5'd21, 8'h00, "R9 R10 ring latency");

    // R2: late counter saturates
    step('0, 0, 1, 5'd26, 8'h01, "R11");
    step('0, 0, 1, 5'd24, 8'h0E, "R2");
    step(9'h100, 0, 0, 5'd0, 8'h00, "R2 reach max");
    step('0, 0, 1, 5'd26, 8'h01, "R11");
    step(9'h100, 0, 0, 5'd0, 8'h00, "R2 R9 held at max");
    step('0, 1, 0, 5'd24, 8'h00, "R2 read");

    // R6: writes ignored outside stop mode
    stop_mode = 1'b0;
    step('0, 0, 1, 5'd3, 8'hAA, "R6");
    step('0, 0, 1, 5'd24, 8'h03, "R6");
    step('0, 1, 0, 5'd3, 8'h00, "R6 ignored");
    step('0, 1, 0, 5'd24, 8'h00, "R6 ignored late");
    step('0, 0, 1, 5'd25, 8'hFF, "R11 clear in run mode");

    // R8: write and event on the same counter
    stop_mode = 1'b1;
    step(9'h004, 0, 1, 5'd7, 8'h5C, "R8");
    step('0, 1, 0, 5'd6, 8'h00, "R8 low");
    step('0, 1, 0, 5'd7, 8'h00, "R8 mid");

    // R11: set wins over clear in the same cycle
    step(9'h002, 0, 1, 5'd25, 8'hFF, "R11 set wins");

    // R4: byte-0 read during an event sees the pre-event value
    load_wide(1, 20'h12FFF, "R4");
    step(9'h002, 1, 0, 5'd3, 8'h00, "R4 low with event");
    step('0, 1, 0, 5'd4, 8'h00, "R4 mid snapshot");
    step('0, 1, 0, 5'd5, 8'h00, "R4 top snapshot");
    step('0, 1, 0, 5'd3, 8'h00, "R4 low after event");

    // R5: stale holding data without byte-0 read
    step(9'h0FF, 0, 0, 5'd0, 8'h00, "R5");
    step('0, 1, 0, 5'd10, 8'h00, "R5 stale mid");

    // R7: counters survive master reset
    load_wide(5, 20'hABCDE, "R7");
    step('0, 0, 1, 5'd24, 8'h09, "R7");
    pulse_reset();
    step('0, 1, 0, 5'd15, 8'h00, "R7 kept low");
    step('0, 1, 0, 5'd16, 8'h00, "R7 kept mid");
    step('0, 1, 0, 5'd17, 8'h00, "R7 kept top");
    step('0, 1, 0, 5'd24, 8'h00, "R7 kept late");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [8:0] ev;
      logic [4:0] a;
      logic [7:0] d;
      bit rd, wr;
      if ($urandom % 20 == 0) stop_mode = ~stop_mode;
      ev = 9'($urandom & $urandom);
      rd = ($urandom % 2) == 0;
      wr = ($urandom % 10) < 3;
      a  = 5'($urandom % 30);
      d  = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
      step(ev, rd, wr, a, d, "");
    end

    done = 1'b1;
    summary();
  end
endmodule